// File: doc/BRIEF.md
# Timer/Counter with Shared Assignable Prescaler

This block is an up-counting timer/counter and a watchdog counter that share one binary prescaler. A control register picks the timer's count source: an internal instruction-cycle enable, or an external pin. With the pin, the register also picks whether rising or falling transitions are counted. The same register decides which of the two counters the prescaler divides for, and it holds a 3-bit division code. The counter that does not own the prescaler is stepped once per source tick.

Software loads the counter value and the control register through a simple write port. A separate strobe clears the watchdog. The block reports the live counter value. It also gives a one-cycle overflow pulse, which feeds a timer interrupt flag elsewhere, and a one-cycle watchdog time-out pulse. The watchdog tick comes from outside, and so does the watchdog enable.

Top module: `shared_prescale_timer`

## Requirements
- R1: After reset the counter reads 0 and both pulses are low. The control register resets to 0: internal clock, prescaler on the timer, code 0. The first 10 cycle ticks after reset therefore advance the counter to 5.
- R2: A write with `wrSel`=0 loads `wrData` into the counter on the next edge. A tick in the same cycle is lost. A write with `wrSel`=1 loads the control register.
- R3: With control bit 5 at 0, the timer source is `cycleEn`: one source tick per clock in which it is high.
- R4: With control bit 5 at 1, the source is `extPin`, taken through a two-flop synchroniser, and `cycleEn` is ignored. Control bit 4 at 0 counts low-to-high transitions; at 1 it counts high-to-low transitions, and rising transitions are ignored.
- R5: With control bit 3 at 0, the prescaler divides timer ticks by 2^(N+1), where N is control bits 2:0 (1:2 to 1:256). The watchdog then counts every enabled `wdTick`.
- R6: With control bit 3 at 1, the prescaler divides enabled watchdog ticks by 2^N (1:1 to 1:128). The timer then counts every source tick.
- R7: The prescaler count is cleared by any control write. It is also cleared by a counter write while the prescaler is on the timer.
- R8: A timer step from 0xFF to 0x00 raises `tmrOvf` for exactly one cycle, in the cycle the counter reads 0x00.
- R9: The watchdog counter (WDT_W bits, default 8) advances only while `wdEnable` is high. When it wraps, `wdTimeout` pulses high for one cycle, which takes 2^WDT_W effective ticks from a cleared state.
- R10: `wdClear` resets the watchdog counter and wins over a tick in the same cycle. When the prescaler is on the watchdog, `wdClear` also resets the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleEn | input | 1 | Instruction-cycle tick, internal timer source |
| extPin | input | 1 | External timer pin, asynchronous |
| wdTick | input | 1 | Watchdog oscillator tick, one cycle wide |
| wdEnable | input | 1 | Watchdog run enable |
| wrEn | input | 1 | Bus write strobe |
| wrSel | input | 1 | Write target: 0 counter, 1 control |
| wrData | input | CNT_W | Write data |
| wdClear | input | 1 | Watchdog clear strobe |
| count | output | CNT_W | Current counter value |
| tmrOvf | output | 1 | Timer overflow pulse |
| wdTimeout | output | 1 | Watchdog time-out pulse |

## Verification
The assertions assume the counter can only change by a write or by a single step per clock. They also assume a write is never combined with another write in the next cycle when checking the loaded value. They treat `wdClear` and `wdEnable` as levels sampled on the clock edge, so a clear or a disabled watchdog must hold off a time-out in the following cycle. The stimulus changes every input just after the falling clock edge. It holds `extPin` at each level for at least four cycles, so each level passes the synchroniser. It keeps `cycleEn` low during control writes, so no tick is counted under a half-changed configuration, except in the single case that deliberately pairs a counter write with a tick.

// File: rtl/spt_pkg.sv
package spt_pkg;
  // prescale code width and the prescaler length it implies
  localparam int CODE_W = 3;
  localparam int PS_W = 2 ** CODE_W;

  // control field positions decoded by the control unit
  localparam int SRC_BIT = 5;
  localparam int EDGE_BIT = 4;
  localparam int ASSIGN_BIT = 3;
  localparam int CTRL_W = SRC_BIT + 1;

  typedef struct packed {
    logic extSrc;
    logic fallEdge;
    logic psToWdt;
    logic [CODE_W-1:0] code;
  } ctrl_t;

  typedef struct packed {
    logic tmrTick;
    logic wdtTick;
    logic cntLoad;
    logic wdClr;
  } strobe_t;

  function automatic ctrl_t decodeCtrl(input logic [CTRL_W-1:0] d);
    ctrl_t c;
    c.extSrc = d[SRC_BIT];
    c.fallEdge = d[EDGE_BIT];
    c.psToWdt = d[ASSIGN_BIT];
    c.code = d[CODE_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/spt_ctrl.sv
module spt_ctrl
  import spt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cycleEn,
  input  logic extPin,
  input  logic wdTick,
  input  logic wdEnable,
  input  logic wrEn,
  input  logic wrSel,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic wdClear,
  output strobe_t strb
);
  ctrl_t ctrlQ;
  logic [1:0] extSync;
  logic extPrev;
  logic [PS_W-1:0] psCnt;
  logic [PS_W-1:0] psMask;
  logic [CODE_W:0] shift;
  logic extTick, srcTick, wdGated, psIn, psOut, psClr;

  // control register and pin synchroniser
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      extSync <= '0;
      extPrev <= 1'b0;
    end else begin
      if (wrEn && wrSel) ctrlQ <= decodeCtrl(ctrlData);
      extSync <= {extSync[0], extPin};
      extPrev <= extSync[1];
    end
  end

  always_comb begin
    extTick = ctrlQ.fallEdge ? (!extSync[1] && extPrev) : (extSync[1] && !extPrev);
    srcTick = ctrlQ.extSrc ? extTick : cycleEn;
    wdGated = wdTick && wdEnable;
    psIn = ctrlQ.psToWdt ? wdGated : srcTick;
    // watchdog side uses the code as is, timer side one step higher
    shift = ctrlQ.psToWdt ? {1'b0, ctrlQ.code} : {1'b0, ctrlQ.code} + 1'b1;
    for (int i = 0; i < PS_W; i++) psMask[i] = (i < int'(shift));
    psOut = psIn && ((psCnt & psMask) == psMask);
    psClr = (wrEn && wrSel) || (wrEn && !wrSel && !ctrlQ.psToWdt)
            || (wdClear && ctrlQ.psToWdt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) psCnt <= '0;
    else if (psClr) psCnt <= '0;
    else if (psIn) psCnt <= psCnt + 1'b1;
  end

  always_comb begin
    strb.tmrTick = ctrlQ.psToWdt ? srcTick : psOut;
    strb.wdtTick = ctrlQ.psToWdt ? psOut : wdGated;
    strb.cntLoad = wrEn && !wrSel;
    strb.wdClr = wdClear;
  end
endmodule

// File: rtl/spt_dp.sv
module spt_dp
  import spt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic tmrOvf,
  output logic wdTimeout
);
  logic [WDT_W-1:0] wdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      tmrOvf <= 1'b0;
    end else begin
      tmrOvf <= 1'b0;
      if (strb.cntLoad) count <= loadVal;
      else if (strb.tmrTick) begin
        count <= count + 1'b1;
        tmrOvf <= (count == '1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt <= '0;
      wdTimeout <= 1'b0;
    end else begin
      wdTimeout <= 1'b0;
      if (strb.wdClr) wdCnt <= '0;
      else if (strb.wdtTick) begin
        wdCnt <= wdCnt + 1'b1;
        wdTimeout <= (wdCnt == '1);
      end
    end
  end
endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer
  import spt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleEn,
  input  logic extPin,
  input  logic wdTick,
  input  logic wdEnable,
  input  logic wrEn,
  input  logic wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic wdClear,
  output logic [CNT_W-1:0] count,
  output logic tmrOvf,
  output logic wdTimeout
);
  strobe_t strb;

  spt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .extPin(extPin),
    .wdTick(wdTick), .wdEnable(wdEnable), .wrEn(wrEn), .wrSel(wrSel),
    .ctrlData(wrData[CTRL_W-1:0]), .wdClear(wdClear), .strb(strb)
  );

  spt_dp #(.CNT_W(CNT_W), .WDT_W(WDT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(wrData),
    .count(count), .tmrOvf(tmrOvf), .wdTimeout(wdTimeout)
  );
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int CNT_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic wrSel,
  input logic [CNT_W-1:0] wrData,
  input logic wdClear,
  input logic wdEnable,
  input logic [CNT_W-1:0] count,
  input logic tmrOvf,
  input logic wdTimeout
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (count == $past(wrData)));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && !wrSel) |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

  assert_ovf_at_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |-> (count == '0));

  assert_ovf_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |=> !tmrOvf);

  assert_timeout_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeout |=> !wdTimeout);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> !wdTimeout);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    wdClear |=> !wdTimeout);
endmodule

bind shared_prescale_timer spt_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .wdClear(wdClear), .wdEnable(wdEnable), .count(count),
  .tmrOvf(tmrOvf), .wdTimeout(wdTimeout)
);

// File: tb/tb_shared_prescale_timer.sv
`timescale 1ns/1ps
module tb_shared_prescale_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleEn = 1'b0, extPin = 1'b0, wdTick = 1'b0, wdEnable = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, wdClear = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] count;
  logic tmrOvf, wdTimeout;

  int tests = 0, fails = 0;
  int ovfSeen = 0, wdtSeen = 0;
  bit done = 0;
  int qKind[$];
  int qExp[$];
  string qTag[$];

  always #5 clk = ~clk;

  shared_prescale_timer dut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .extPin(extPin),
    .wdTick(wdTick), .wdEnable(wdEnable), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .wdClear(wdClear), .count(count),
    .tmrOvf(tmrOvf), .wdTimeout(wdTimeout)
  );

  // kinds: 0 count, 1 tmrOvf level, 2 wdTimeout level, 3 overflow pulses, 4 time-out pulses
  task automatic expectItem(int kind, int exp, string tag);
    qKind.push_back(kind);
    qExp.push_back(exp);
    qTag.push_back(tag);
  endtask

  // monitor: counts pulses, then pops and compares queued expectations
  initial forever begin
    @(negedge clk);
    #1;
    if (rstN && tmrOvf) ovfSeen++;
    if (rstN && wdTimeout) wdtSeen++;
    while (qKind.size() > 0) begin
      int k, e, act;
      string t;
      k = qKind.pop_front();
      e = qExp.pop_front();
      t = qTag.pop_front();
      case (k)
        0: act = int'(count);
        1: act = int'(tmrOvf);
        2: act = int'(wdTimeout);
        3: act = ovfSeen;
        default: act = wdtSeen;
      endcase
      tests++;
      if (act != e) begin
        fails++;
        $display("FAIL %s kind %0d actual %0d expected %0d", t, k, act, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(logic sel, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cycTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycleEn = 1'b1;
    end
    @(negedge clk);
    cycleEn = 1'b0;
  endtask

  task automatic wdTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wdTick = 1'b1;
    end
    @(negedge clk);
    wdTick = 1'b0;
  endtask

  task automatic wdClr();
    @(negedge clk);
    wdClear = 1'b1;
    @(negedge clk);
    wdClear = 1'b0;
  endtask

  task automatic pinPulse();
    @(negedge clk);
    extPin = 1'b1;
    idle(4);
    extPin = 1'b0;
    idle(4);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    expectItem(0, 0, "R1 count after reset");
    expectItem(1, 0, "R1 tmrOvf after reset");
    expectItem(2, 0, "R1 wdTimeout after reset");
    cycTicks(10);
    expectItem(0, 5, "R1 default control divides by 2");

    // internal source, prescaler away from timer
    busWrite(1'b1, 8'h08);
    busWrite(1'b0, 8'h10);
    expectItem(0, 8'h10, "R2 counter load");
    cycTicks(20);
    expectItem(0, 8'h24, "R3 internal cycle ticks");

    // prescaler on timer
    busWrite(1'b1, 8'h02);
    busWrite(1'b0, 8'h00);
    cycTicks(64);
    expectItem(0, 8, "R5 code 2 divides by 8");
    cycTicks(7);
    expectItem(0, 8, "R5 code 2 partial period");
    cycTicks(1);
    expectItem(0, 9, "R5 code 2 period completes");
    busWrite(1'b1, 8'h07);
    busWrite(1'b0, 8'h00);
    cycTicks(512);
    expectItem(0, 2, "R5 code 7 divides by 256");

    // prescaler clearing
    busWrite(1'b1, 8'h02);
    busWrite(1'b0, 8'h00);
    cycTicks(5);
    busWrite(1'b0, 8'h00);
    cycTicks(5);
    expectItem(0, 0, "R7 counter write clears prescaler");
    cycTicks(3);
    expectItem(0, 1, "R7 period after counter write");
    busWrite(1'b1, 8'h02);
    cycTicks(7);
    expectItem(0, 1, "R7 control write clears prescaler");
    cycTicks(1);
    expectItem(0, 2, "R7 period after control write");

    // prescaler on watchdog: timer at 1:1
    busWrite(1'b1, 8'h0F);
    busWrite(1'b0, 8'h00);
    cycTicks(9);
    expectItem(0, 9, "R6 timer undivided");

    // overflow
    busWrite(1'b1, 8'h08);
    busWrite(1'b0, 8'hFE);
    cycTicks(1);
    expectItem(0, 8'hFF, "R8 count before wrap");
    expectItem(1, 0, "R8 no pulse before wrap");
    cycTicks(1);
    expectItem(0, 0, "R8 wrap to zero");
    expectItem(1, 1, "R8 pulse on wrap");
    expectItem(3, 1, "R8 one overflow pulse");
    idle(1);
    expectItem(1, 0, "R8 pulse ends");

    // load wins over a simultaneous tick
    @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b0; wrData = 8'h40; cycleEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; cycleEn = 1'b0;
    expectItem(0, 8'h40, "R2 load beats tick");

    // external pin, rising edges, cycleEn ignored
    busWrite(1'b1, 8'h28);
    busWrite(1'b0, 8'h00);
    cycleEn = 1'b1;
    pinPulse();
    pinPulse();
    pinPulse();
    cycleEn = 1'b0;
    expectItem(0, 3, "R4 three rising edges");

    // external pin, falling edges
    busWrite(1'b1, 8'h38);
    busWrite(1'b0, 8'h00);
    @(negedge clk);
    extPin = 1'b1;
    idle(4);
    expectItem(0, 0, "R4 rising edge ignored in falling mode");
    extPin = 1'b0;
    idle(4);
    expectItem(0, 1, "R4 falling edge counted");

    // watchdog disabled
    busWrite(1'b1, 8'h00);
    wdTicks(300);
    expectItem(4, 0, "R9 disabled watchdog silent");
    wdEnable = 1'b1;
    wdClr();
    wdTicks(255);
    expectItem(4, 0, "R5 watchdog undivided, no wrap yet");
    wdTicks(1);
    expectItem(2, 1, "R9 time-out pulse");
    expectItem(4, 1, "R9 one time-out");
    idle(1);
    expectItem(2, 0, "R9 time-out pulse ends");

    // prescaler on watchdog, code 1 (1:2)
    busWrite(1'b1, 8'h09);
    wdClr();
    wdTicks(511);
    expectItem(4, 1, "R6 watchdog 1:2 not yet");
    wdTicks(1);
    expectItem(4, 2, "R6 watchdog 1:2 wraps");

    // code 0 on watchdog is 1:1
    busWrite(1'b1, 8'h08);
    wdClr();
    wdTicks(256);
    expectItem(4, 3, "R6 watchdog code 0 undivided");

    // clear resets watchdog counter
    wdClr();
    wdTicks(200);
    wdClr();
    wdTicks(200);
    expectItem(4, 3, "R10 clear restarts watchdog");
    wdTicks(56);
    expectItem(4, 4, "R10 wrap after clear");

    // clear resets prescaler when on watchdog
    busWrite(1'b1, 8'h09);
    wdClr();
    wdTicks(1);
    wdClr();
    wdTicks(511);
    expectItem(4, 4, "R10 clear resets prescaler");
    wdTicks(1);
    expectItem(4, 5, "R10 wrap after prescaler clear");

    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule